// File: doc/BRIEF.md
# Chained Converter Serial Readout Controller

This block sits on the host side of a three-wire serial port that serves a chain of identical 18-bit successive-approximation converters. A start request makes it pulse the convert line. It then watches the data input, which stays high while the chain is still converting, and after that issues exactly 18×N+1 falling clock edges. The chain sends one shared busy bit ahead of the data, not one per device, so the first captured bit is thrown away. The remaining bits are split into N words.

Each word is re-coded from offset binary, where mid-scale is 0x20000, into two's complement. The words go out on a valid/ready stream, nearest device first, each tagged with its position in the chain. A one-cycle done pulse follows acceptance of the final word. If the busy level stays high too long, a timeout pulse ends the attempt and no words are sent. The chain length is a parameter from 1 to 8, and the serial clock half-period is a run-time input counted in system clocks.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset, sclk is high, and conv, m_valid, frame_done, timeout_err and active are all low.
- R2: A start seen while idle makes conv high for exactly one cycle, on the cycle after start. A start seen while active is ignored and produces no further conv pulse.
- R3: While sdi is sampled high after the conversion pulse, no sclk edge occurs. If sdi is high on busy_limit consecutive samples (busy_limit nonzero), timeout_err pulses for one cycle, the block returns to idle, and it presents no word.
- R4: A frame has exactly 18×NDEV+1 falling edges of sclk. Each low and each high phase lasts max(sclk_half,1) system clocks, and sclk rests high outside a frame.
- R5: sdi is sampled on each rising edge of sclk. The first sampled bit is discarded whatever its value.
- R6: Words come out in chain order. Word k, tagged m_dev = k, is built from captured data bits 18k+1 to 18k+18 counted after the discarded bit, first-received bit as the MSB.
- R7: m_data is the received word with bit 17 inverted: offset-binary 0x20000 comes out as 0, 0x00000 as 0x20000, and 0x3FFFF as 0x1FFFF.
- R8: While m_valid is high and m_ready is low, m_valid stays high and m_data and m_dev stay unchanged.
- R9: frame_done is a single-cycle pulse in the cycle after the last word is accepted. active is low from then on.
- R10: m_valid never rises during a frame's clocking, and sclk is high whenever m_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion and readout |
| sclk_half | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| busy_limit | input | TO_W | Busy-high samples allowed before timeout (nonzero) |
| conv | output | 1 | Conversion start pulse to the chain |
| sclk | output | 1 | Serial clock to the chain, rests high |
| sdi | input | 1 | Serial data from the last converter in the chain |
| m_valid | output | 1 | Result word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 18 | Result in two's complement |
| m_dev | output | 3 | Chain position of the word, 0 nearest host |
| frame_done | output | 1 | One-cycle pulse after the last word is accepted |
| timeout_err | output | 1 | One-cycle pulse when busy stayed high too long |
| active | output | 1 | Controller is busy with a frame |

## Verification
A bit counter that is off by one shows at the ports straight away. The count of falling edges in the frame no longer matches 18×N+1, and every word is shifted by one bit position, so the first accepted word already carries wrong data. A device index that goes wrong shows as swapped words or wrong m_dev tags in the very first frame. A stuck busy or timeout counter shows as a missing or early timeout pulse on the boundary cases one sample below and at the limit. A flaw in the stall logic shows as data changing under a low m_ready.

// File: rtl/adc_rd_pkg.sv
// Shared constants, state encoding and result re-coding for the chained
// converter readout controller.
package adc_rd_pkg;
    localparam int RES_W     = 18;  // bits per converter result
    localparam int DEV_IDX_W = 3;   // device tag width, chain length up to 8

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_WAIT,
        ST_SHIFT,
        ST_EMIT
    } rd_state_t;

    // Offset binary to two's complement: flip the sign position.
    function automatic logic [RES_W-1:0] ob_to_tc(input logic [RES_W-1:0] ob);
        return {~ob[RES_W-1], ob[RES_W-2:0]};
    endfunction
endpackage

// File: rtl/adc_rd_sclk.sv
// Serial clock generator. While run is high, sclk toggles every
// max(half,1) system clocks, starting from its high rest level, so the
// first toggle is a falling edge. rise_tick marks the system clock edge on
// which sclk goes high again; the capture logic samples data on that edge.
// Assumes half is held stable while run is high.
module adc_rd_sclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sclk,
    output logic             rise_tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic             at_end;

    // Effective half-period, zero treated as one.
    always_comb limit = (half == '0) ? DIV_W'(1) : half;

    // Marks the last system clock of the current phase.
    always_comb at_end = (cnt == limit - DIV_W'(1));

    // Phase counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (at_end) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // Rising-edge marker used to sample the serial input.
    always_comb rise_tick = run && at_end && !sclk;
endmodule

// File: rtl/adc_rd_capture.sv
// Frame capture. Counts sampled bits of one frame (18*NDEV+1 bits), drops
// the first one (the shared busy bit) and shifts the rest in, first bit at
// the top. last_bit flags the tick that samples the final bit.
// Assumes clear is high for at least one cycle before a frame starts.
module adc_rd_capture #(
    parameter int NDEV  = 4,
    parameter int RES_W = 18
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  bit_tick,
    input  logic                  sdi,
    output logic [RES_W*NDEV-1:0] frame,
    output logic                  last_bit
);
    localparam int DATA_W = RES_W * NDEV;
    localparam int TOT    = DATA_W + 1;
    localparam int CNT_W  = $clog2(TOT + 1);

    logic [CNT_W-1:0] bit_idx;

    // Bit counter and data shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_idx <= '0;
            frame   <= '0;
        end else if (clear) begin
            bit_idx <= '0;
        end else if (bit_tick) begin
            bit_idx <= bit_idx + CNT_W'(1);
            if (bit_idx != '0) begin
                frame <= {frame[DATA_W-2:0], sdi};
            end
        end
    end

    // Final bit of the frame is being sampled.
    always_comb last_bit = bit_tick && (bit_idx == CNT_W'(TOT - 1));
endmodule

// File: rtl/adc_rd_emit.sv
// Result streamer. On load it presents the captured words one at a time,
// device 0 (first received) first, re-coded to two's complement and tagged
// with the device index. last_accept marks the handshake of the final word.
// Assumes frame is stable from load until the last word is accepted.
module adc_rd_emit #(
    parameter int NDEV  = 4,
    parameter int RES_W = 18
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [RES_W*NDEV-1:0]               frame,
    input  logic                                m_ready,
    output logic                                m_valid,
    output logic [RES_W-1:0]                    m_data,
    output logic [adc_rd_pkg::DEV_IDX_W-1:0]    m_dev,
    output logic                                last_accept
);
    import adc_rd_pkg::*;

    localparam int DATA_W = RES_W * NDEV;

    logic [DEV_IDX_W-1:0] idx;
    logic [RES_W-1:0]     word;
    logic                 is_last;

    // Index of the final device in the chain.
    always_comb is_last = (idx == DEV_IDX_W'(NDEV - 1));

    // Valid flag and device index walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            idx     <= '0;
        end else if (load) begin
            m_valid <= 1'b1;
            idx     <= '0;
        end else if (m_valid && m_ready) begin
            if (is_last) begin
                m_valid <= 1'b0;
            end else begin
                idx <= idx + DEV_IDX_W'(1);
            end
        end
    end

    // Word select from the frame and re-coding.
    always_comb begin
        word   = frame[DATA_W-1 - int'(idx)*RES_W -: RES_W];
        m_data = ob_to_tc(word);
        m_dev  = idx;
    end

    // Handshake of the last word.
    always_comb last_accept = m_valid && m_ready && is_last;
endmodule

// File: rtl/adc_chain_reader.sv
// Readout controller for NDEV chained 18-bit converters on a three-wire
// port. Sequence: convert pulse, wait for the busy level on sdi to drop
// (with timeout), clock 18*NDEV+1 falling edges, drop the busy bit, then
// stream NDEV two's complement words. Assumes sdi is already synchronous
// to clk and changes only after sclk falling edges.
module adc_chain_reader #(
    parameter int NDEV  = 4,
    parameter int DIV_W = 8,
    parameter int TO_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] sclk_half,
    input  logic [TO_W-1:0]  busy_limit,
    output logic             conv,
    output logic             sclk,
    input  logic             sdi,
    output logic             m_valid,
    input  logic             m_ready,
    output logic [17:0]      m_data,
    output logic [2:0]       m_dev,
    output logic             frame_done,
    output logic             timeout_err,
    output logic             active
);
    import adc_rd_pkg::*;

    rd_state_t              state;
    logic [TO_W-1:0]        wait_cnt;
    logic                   rise_tick;
    logic                   last_bit;
    logic                   last_accept;
    logic [RES_W*NDEV-1:0]  frame;

    // Sequencer: conversion, busy wait with timeout, clocking, streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            wait_cnt    <= '0;
            conv        <= 1'b0;
            frame_done  <= 1'b0;
            timeout_err <= 1'b0;
        end else begin
            conv        <= 1'b0;
            frame_done  <= 1'b0;
            timeout_err <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_CONV;
                    conv  <= 1'b1;
                end
                ST_CONV: begin
                    state    <= ST_WAIT;
                    wait_cnt <= '0;
                end
                ST_WAIT: begin
                    if (!sdi) begin
                        state <= ST_SHIFT;
                    end else if (wait_cnt == busy_limit - TO_W'(1)) begin
                        state       <= ST_IDLE;
                        timeout_err <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + TO_W'(1);
                    end
                end
                ST_SHIFT: if (last_bit) state <= ST_EMIT;
                ST_EMIT: if (last_accept) begin
                    state      <= ST_IDLE;
                    frame_done <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Busy flag seen by the host.
    always_comb active = (state != ST_IDLE);

    adc_rd_sclk #(.DIV_W(DIV_W)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == ST_SHIFT),
        .half      (sclk_half),
        .sclk      (sclk),
        .rise_tick (rise_tick)
    );

    adc_rd_capture #(.NDEV(NDEV), .RES_W(RES_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_CONV),
        .bit_tick (rise_tick && (state == ST_SHIFT)),
        .sdi      (sdi),
        .frame    (frame),
        .last_bit (last_bit)
    );

    adc_rd_emit #(.NDEV(NDEV), .RES_W(RES_W)) u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        ((state == ST_SHIFT) && last_bit),
        .frame       (frame),
        .m_ready     (m_ready),
        .m_valid     (m_valid),
        .m_data      (m_data),
        .m_dev       (m_dev),
        .last_accept (last_accept)
    );
endmodule

// File: rtl/adc_chain_reader_chk.sv
// Port-level checker for the readout controller, bound to every instance.
module adc_chain_reader_chk #(
    parameter int NDEV = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        conv,
    input logic        sclk,
    input logic        m_valid,
    input logic        m_ready,
    input logic [17:0] m_data,
    input logic [2:0]  m_dev,
    input logic        frame_done,
    input logic        timeout_err,
    input logic        active
);
    // Convert pulse lasts one cycle and only occurs inside a frame.
    p_conv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv |-> active ##1 !conv);

    // Clock rests high when idle.
    p_sclk_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sclk);

    // Timeout returns to idle with nothing to present.
    p_timeout_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !active && !m_valid);

    // Stalled word holds.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_dev));

    // Done pulse is single-cycle and leaves the block idle.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !active ##1 !frame_done);

    // Words only while the serial clock rests high.
    p_valid_sclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> sclk);

    // Device tag within the chain.
    p_dev_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (int'(m_dev) < NDEV));
endmodule

bind adc_chain_reader adc_chain_reader_chk #(.NDEV(NDEV)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv        (conv),
    .sclk        (sclk),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_data      (m_data),
    .m_dev       (m_dev),
    .frame_done  (frame_done),
    .timeout_err (timeout_err),
    .active      (active)
);

// File: tb/adc_chain_reader_tb.sv
module adc_chain_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int TOT = 18 * N + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  sclk_half = 8'd1;
    logic [15:0] busy_limit = 16'd200;
    logic        conv, sclk, sdi, m_valid, m_ready, frame_done, timeout_err, active;
    logic [17:0] m_data;
    logic [2:0]  m_dev;

    int checks = 0;
    int errors = 0;

    // Chain model state
    logic [TOT-1:0] frame_bits = '0;
    logic [17:0]    vals [N];
    int  dur = 1;
    int  busy_rem = 0;
    logic busy_line = 1'b0;
    int  fe_cnt = 0;
    int  fe_base = 0;
    int  low_cnt = 0;

    // Monitor state
    int  rx_cnt = 0, done_cnt = 0, to_cnt = 0, conv_cnt = 0;
    int  ready_mode = 0;
    logic        prev_stall = 1'b0;
    logic [17:0] prev_data = '0;
    logic [2:0]  prev_dev = '0;

    adc_chain_reader #(.NDEV(N), .DIV_W(8), .TO_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sclk_half(sclk_half),
        .busy_limit(busy_limit), .conv(conv), .sclk(sclk), .sdi(sdi),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_dev(m_dev),
        .frame_done(frame_done), .timeout_err(timeout_err), .active(active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] exp_word(input logic [17:0] ob);
        return ob ^ 18'h20000;
    endfunction

    // Converter chain model: busy level after conv, then one bit per falling edge.
    always @(posedge clk) begin
        if (conv) begin
            busy_line <= 1'b1;
            busy_rem  <= dur;
        end else if (busy_line) begin
            if (busy_rem <= 1) busy_line <= 1'b0;
            else busy_rem <= busy_rem - 1;
        end
        if (!sclk) low_cnt <= low_cnt + 1;
    end

    always @(negedge sclk) fe_cnt = fe_cnt + 1;

    always_comb begin
        int k;
        k = fe_cnt - fe_base;
        if (busy_line) sdi = 1'b1;
        else if (k <= 0 || k > TOT) sdi = 1'b0;
        else sdi = frame_bits[TOT - k];
    end

    // Ready driver and output monitor, away from the active edge.
    initial begin
        m_ready = 1'b1;
        forever begin
            @(negedge clk);
            m_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom % 2);
            #1;
            if (rst_n) begin
                if (prev_stall) begin
                    chk(m_valid && m_data == prev_data && m_dev == prev_dev,
                        "R8", "stalled word changed", {m_dev, m_data}, {prev_dev, prev_data});
                end
                if (m_valid && m_ready) begin
                    if (rx_cnt < N) begin
                        chk(m_data == exp_word(vals[rx_cnt]), "R7", "word value",
                            m_data, exp_word(vals[rx_cnt]));
                        chk(m_dev == 3'(rx_cnt), "R6", "device tag order", m_dev, rx_cnt);
                    end
                    rx_cnt++;
                end
                prev_stall = m_valid && !m_ready;
                prev_data  = m_data;
                prev_dev   = m_dev;
                if (frame_done) done_cnt++;
                if (timeout_err) to_cnt++;
                if (conv) conv_cnt++;
            end
        end
    end

    // One readout attempt with full checking.
    task automatic run_frame(input logic [7:0] div, input int d, input logic [15:0] lim,
                             input bit busy_bit, input bit exp_to, input bit poke);
        int eff;
        eff = (div == 0) ? 1 : int'(div);
        frame_bits[TOT-1] = busy_bit;
        for (int i = 0; i < N; i++) frame_bits[TOT-2 - i*18 -: 18] = vals[i];
        @(negedge clk);
        sclk_half = div; busy_limit = lim; dur = d;
        fe_base = fe_cnt; low_cnt = 0;
        rx_cnt = 0; done_cnt = 0; to_cnt = 0; conv_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #2;
        chk(conv == 1'b1, "R2", "conv after start", conv, 1);
        @(negedge clk); #2;
        chk(conv == 1'b0, "R2", "conv one cycle", conv, 0);
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            start = (poke && c == 60) ? 1'b1 : 1'b0;
            #2;
            if (done_cnt > 0 || to_cnt > 0) break;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        chk(conv_cnt == 1, "R2", "conv pulses per attempt", conv_cnt, 1);
        if (exp_to) begin
            chk(to_cnt == 1, "R3", "timeout pulses", to_cnt, 1);
            chk(rx_cnt == 0, "R3", "words after timeout", rx_cnt, 0);
            chk(fe_cnt - fe_base == 0, "R3", "edges after timeout", fe_cnt - fe_base, 0);
            chk(active == 1'b0, "R3", "idle after timeout", active, 0);
            while (busy_line) @(negedge clk);
        end else begin
            chk(to_cnt == 0, "R3", "no timeout", to_cnt, 0);
            chk(fe_cnt - fe_base == TOT, "R4", "falling edges", fe_cnt - fe_base, TOT);
            chk(low_cnt == TOT * eff, "R4", "low phase clocks", low_cnt, TOT * eff);
            chk(rx_cnt == N, "R5", "words received", rx_cnt, N);
            chk(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
            chk(active == 1'b0 && sclk == 1'b1, "R9", "idle after frame", {active, sclk}, 2'b01);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #2;
        chk(sclk == 1'b1 && conv == 1'b0 && m_valid == 1'b0 && frame_done == 1'b0
            && timeout_err == 1'b0 && active == 1'b0, "R1", "reset outputs",
            {sclk, conv, m_valid, frame_done, timeout_err, active}, 6'b100000);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 corner codes, busy bit high must be dropped (R5), fastest clock
        vals[0] = 18'h20000; vals[1] = 18'h00000; vals[2] = 18'h3FFFF; vals[3] = 18'h1FFFF;
        run_frame(8'd0, 3, 16'd200, 1'b1, 1'b0, 1'b0);

        // R6 distinct pattern, slower clock, stalls, start poked mid-frame (R2)
        vals[0] = 18'h12345; vals[1] = 18'h2ABCD; vals[2] = 18'h00001; vals[3] = 18'h3FFFE;
        ready_mode = 1;
        run_frame(8'd3, 5, 16'd200, 1'b0, 1'b0, 1'b1);

        // R3 boundary: one sample below the limit, then at the limit
        run_frame(8'd2, 9, 16'd10, 1'b0, 1'b0, 1'b0);
        run_frame(8'd2, 10, 16'd10, 1'b0, 1'b1, 1'b0);

        // Random frames
        for (int f = 0; f < 10; f++) begin
            for (int i = 0; i < N; i++) vals[i] = 18'($urandom);
            ready_mode = f % 2;
            run_frame(8'($urandom % 4), 1 + int'($urandom % 30), 16'd100,
                      1'($urandom % 2), 1'b0, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule